// File: doc/BRIEF.md
# Signed/Unsigned 32-by-16 Divider

This block divides a 32-bit dividend by a 16-bit divisor, treating both as unsigned or as two's-complement values according to a mode select sampled with the start strobe. It produces one packed 32-bit word that holds a 16-bit remainder and a 16-bit quotient. It also updates four condition flags: negative (N), zero (Z), overflow (V) and carry (C). A processor datapath uses it as the execution unit for its long-divide operations. The datapath supplies operands it has already fetched, waits for `done_o`, and then writes `result_o` and the flags back.

Internally the operands are reduced to magnitudes. A restoring divider retires one quotient bit per clock. At the end the signs are restored and the quotient is checked against the 16-bit range. Two conditions are reported and not handled further. A zero divisor gives a one-cycle exception pulse. A quotient that does not fit in 16 bits sets V. In both cases the destination word keeps the original dividend. Raising the exception itself is the job of surrounding logic.

Top module: `qrdiv_top`

## Requirements
- R1: After a clock edge with `rst_n` low, `result_o` is 0, all four flags are 0, and `busy_o`, `done_o` and `div_zero_o` are 0.
- R2: A start strobe sampled while idle is accepted, and `busy_o` is 1 from the next cycle until the result is presented. A start strobe sampled while `busy_o` is 1 is ignored and changes neither the running operation nor its result.
- R3: `done_o` is 1 for exactly one cycle, after the 33rd rising edge that follows the edge that accepted start. `busy_o` falls on that same edge.
- R4: In unsigned mode (`signed_i` = 0), a successful divide gives `result_o[31:16]` = remainder and `result_o[15:0]` = quotient of the plain unsigned division.
- R5: In signed mode (`signed_i` = 1), the divisor is sign-extended from bit 15. The quotient truncates toward zero, and the remainder takes the sign of the dividend. Both are packed as in R4, in two's complement.
- R6: On success V = 0, Z = 1 exactly when the 16-bit quotient is zero, and N = quotient bit 15.
- R7: A zero divisor gives `div_zero_o` = 1 in the same cycle as `done_o`, with N = 0, Z = 1 and V = 0. `result_o` then equals the dividend.
- R8: If the quotient does not fit in 16 bits, V = 1 and `result_o` equals the dividend. N and Z keep the values they had before the operation.
- R9: C is 0 after every outcome: success, overflow and zero divisor.
- R10: The fit test accepts -32768 to 32767 in signed mode and 0 to 65535 in unsigned mode. For example, 0xFFFF8000 divided by 1 (signed) succeeds, while 0x00008000 divided by 1 (signed) and 0x80000000 divided by -1 overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a divide with the operands presented this cycle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor |
| result_o | output | 32 | Remainder in [31:16], quotient in [15:0]; dividend on overflow or zero divisor |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, always cleared by a divide |
| div_zero_o | output | 1 | One-cycle pulse for a zero divisor, coincident with done |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle pulse: result and flags are valid |

## Verification
All results, flags and the zero-divisor pulse are due together, in the cycle after the 33rd rising edge that follows the edge that sampled start. The only earlier effect is `busy_o`, which rises one edge after start. The bench drives inputs on falling edges and counts the rising edges explicitly from the accepting edge. It checks `busy_o` just before the final edge, then samples every result on the falling edge after edge 33, and confirms one edge later that `done_o` and `div_zero_o` have dropped. A start pulse injected in the middle of a run must leave that timing and the result intact.

// File: rtl/qrdiv_pkg.sv
// Package: shared types for the 32-by-16 divider.
// Holds the sequencer state encoding and the condition-flag record.
package qrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

endpackage

// File: rtl/qrdiv_prep.sv
// Module: qrdiv_prep
// Reduces raw operands to magnitudes and sign bits for the unsigned core.
// Assumes: purely combinational; signed mode sign-extends the divisor from its top bit.
module qrdiv_prep #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             signed_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [DVD_W-1:0] dvd_mag_o,
    output logic [DVS_W:0]   dvs_mag_o,
    output logic             dvd_neg_o,
    output logic             dvs_neg_o,
    output logic             dvs_zero_o
);

    logic [DVS_W:0] dvs_ext;

    // Sign extension of the divisor by one bit so that -2^(DVS_W-1) has a magnitude.
    always_comb begin
        dvs_ext    = {signed_i & divisor_i[DVS_W-1], divisor_i};
        dvs_neg_o  = dvs_ext[DVS_W];
        dvs_mag_o  = dvs_neg_o ? (-dvs_ext) : dvs_ext;
        dvs_zero_o = (divisor_i == '0);
    end

    // Dividend magnitude: negate only when signed and the top bit is set.
    always_comb begin
        dvd_neg_o = signed_i & dividend_i[DVD_W-1];
        dvd_mag_o = dvd_neg_o ? (-dividend_i) : dividend_i;
    end

endmodule

// File: rtl/qrdiv_core.sv
// Module: qrdiv_core
// Restoring divider on magnitudes: one quotient bit per step, MSB first.
// Assumes: load and step are never asserted together; after DVD_W steps the
// quotient register holds the full quotient and the remainder register the remainder.
module qrdiv_core #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DVD_W-1:0] dvd_mag_i,
    input  logic [DVS_W:0]   dvs_mag_i,
    output logic [DVD_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);

    localparam int RW = DVS_W + 1;

    logic [RW-1:0]    rem_q;
    logic [RW-1:0]    dvs_q;
    logic [DVD_W-1:0] quo_q;
    logic [RW:0]      trial;
    logic             fits_sub;
    logic [RW-1:0]    rem_next;

    // Trial subtraction: shift in the next dividend bit and compare with the divisor.
    always_comb begin
        trial    = {rem_q, quo_q[DVD_W-1]};
        fits_sub = trial[RW] | (trial[RW-1:0] >= dvs_q);
        rem_next = fits_sub ? (trial[RW-1:0] - dvs_q) : trial[RW-1:0];
    end

    // Iteration registers: load clears the partial remainder, step retires one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            dvs_q <= dvs_mag_i;
            quo_q <= dvd_mag_i;
        end else if (step_i) begin
            rem_q <= rem_next;
            quo_q <= {quo_q[DVD_W-2:0], fits_sub};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q[DVS_W-1:0];

    // The partial remainder never reaches the divisor when the divisor is nonzero.
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q)); // R4

endmodule

// File: rtl/qrdiv_post.sv
// Module: qrdiv_post
// Restores signs of quotient and remainder and tests whether the quotient fits.
// Assumes: magnitudes come from a finished core run; remainder magnitude fits QUO_W bits.
module qrdiv_post #(
    parameter int DVD_W = 32,
    parameter int QUO_W = 16
) (
    input  logic             signed_i,
    input  logic             dvd_neg_i,
    input  logic             dvs_neg_i,
    input  logic [DVD_W-1:0] quo_mag_i,
    input  logic [QUO_W-1:0] rem_mag_i,
    output logic [QUO_W-1:0] quo_o,
    output logic [QUO_W-1:0] rem_o,
    output logic             fits_o
);

    localparam logic [DVD_W-1:0] SPOS_MAX = {{(DVD_W-QUO_W+1){1'b0}}, {(QUO_W-1){1'b1}}};
    localparam logic [DVD_W-1:0] SNEG_MAX = SPOS_MAX + 1'b1;
    localparam logic [DVD_W-1:0] UNS_MAX  = {{(DVD_W-QUO_W){1'b0}}, {QUO_W{1'b1}}};

    logic q_neg;

    // Sign fix-up: quotient negative when signs differ, remainder follows the dividend.
    always_comb begin
        q_neg = signed_i & (dvd_neg_i ^ dvs_neg_i);
        quo_o = q_neg ? (-quo_mag_i[QUO_W-1:0]) : quo_mag_i[QUO_W-1:0];
        rem_o = dvd_neg_i ? (-rem_mag_i) : rem_mag_i;
    end

    // Range test on the full magnitude against the mode's 16-bit limits.
    always_comb begin
        if (!signed_i)
            fits_o = (quo_mag_i <= UNS_MAX);
        else if (q_neg)
            fits_o = (quo_mag_i <= SNEG_MAX);
        else
            fits_o = (quo_mag_i <= SPOS_MAX);
    end

endmodule

// File: rtl/qrdiv_top.sv
// Module: qrdiv_top
// Sequenced 32-by-16 divide with packed remainder/quotient result and condition flags.
// Assumes: DVD_W == 2*DVS_W; start is sampled only when idle; fixed latency of
// DVD_W+1 edges after the accepting edge for every outcome, including a zero divisor.
module qrdiv_top
    import qrdiv_pkg::*;
#(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [DVD_W-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_c_o,
    output logic             div_zero_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);

    div_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             load;
    logic             step;

    logic [DVD_W-1:0] pre_dvd_mag;
    logic [DVS_W:0]   pre_dvs_mag;
    logic             pre_dvd_neg;
    logic             pre_dvs_neg;
    logic             pre_dvs_zero;

    logic             sgn_q;
    logic [DVD_W-1:0] dvd_q;
    logic             dvd_neg_q;
    logic             dvs_neg_q;
    logic             dvs_zero_q;

    logic [DVD_W-1:0] core_quo;
    logic [DVS_W-1:0] core_rem;
    logic [DVS_W-1:0] fin_quo;
    logic [DVS_W-1:0] fin_rem;
    logic             fin_fits;

    logic [DVD_W-1:0] result_q;
    cc_flags_t        flags_q;
    logic             done_q;
    logic             dz_q;

    assign load = (state_q == ST_IDLE) && start_i;
    assign step = (state_q == ST_RUN);

    qrdiv_prep #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_prep (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .dvd_mag_o  (pre_dvd_mag),
        .dvs_mag_o  (pre_dvs_mag),
        .dvd_neg_o  (pre_dvd_neg),
        .dvs_neg_o  (pre_dvs_neg),
        .dvs_zero_o (pre_dvs_zero)
    );

    qrdiv_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .dvd_mag_i (pre_dvd_mag),
        .dvs_mag_i (pre_dvs_mag),
        .quo_o     (core_quo),
        .rem_o     (core_rem)
    );

    qrdiv_post #(.DVD_W(DVD_W), .QUO_W(DVS_W)) u_post (
        .signed_i  (sgn_q),
        .dvd_neg_i (dvd_neg_q),
        .dvs_neg_i (dvs_neg_q),
        .quo_mag_i (core_quo),
        .rem_mag_i (core_rem),
        .quo_o     (fin_quo),
        .rem_o     (fin_rem),
        .fits_o    (fin_fits)
    );

    // Sequencer: idle -> DVD_W steps -> one finishing cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_STEP)
                        state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operand capture at the accepting edge; held through the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q      <= 1'b0;
            dvd_q      <= '0;
            dvd_neg_q  <= 1'b0;
            dvs_neg_q  <= 1'b0;
            dvs_zero_q <= 1'b0;
        end else if (load) begin
            sgn_q      <= signed_i;
            dvd_q      <= dividend_i;
            dvd_neg_q  <= pre_dvd_neg;
            dvs_neg_q  <= pre_dvs_neg;
            dvs_zero_q <= pre_dvs_zero;
        end
    end

    // Result and flag update in the finishing cycle, by outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            done_q   <= 1'b0;
            dz_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            if (state_q == ST_FIN) begin
                done_q    <= 1'b1;
                flags_q.c <= 1'b0;
                if (dvs_zero_q) begin
                    dz_q      <= 1'b1;
                    result_q  <= dvd_q;
                    flags_q.n <= 1'b0;
                    flags_q.z <= 1'b1;
                    flags_q.v <= 1'b0;
                end else if (!fin_fits) begin
                    result_q  <= dvd_q;
                    flags_q.v <= 1'b1;
                end else begin
                    result_q  <= {fin_rem, fin_quo};
                    flags_q.n <= fin_quo[DVS_W-1];
                    flags_q.z <= (fin_quo == '0);
                    flags_q.v <= 1'b0;
                end
            end
        end
    end

    assign result_o   = result_q;
    assign flag_n_o   = flags_q.n;
    assign flag_z_o   = flags_q.z;
    assign flag_v_o   = flags_q.v;
    assign flag_c_o   = flags_q.c;
    assign div_zero_o = dz_q;
    assign done_o     = done_q;
    assign busy_o     = (state_q != ST_IDLE);

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DZ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (done_o && flag_z_o && !flag_n_o && !flag_v_o && !flag_c_o)); // R7

    AST_HOLD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (flag_v_o || div_zero_o)) |-> (result_o == dvd_q)); // R8

    AST_OVF_KEEPS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flag_v_o) |-> (flag_n_o == $past(flag_n_o) && flag_z_o == $past(flag_z_o))); // R8

    AST_NO_OVERFLOW_ON_ZERO_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o && !flag_v_o) |-> (flag_z_o == (result_o[DVS_W-1:0] == '0))); // R6

endmodule

// File: tb/qrdiv_top_test.sv
module qrdiv_top_test;

    logic        clk;
    logic        rst_n;
    logic        start_i;
    logic        signed_i;
    logic [31:0] dividend_i;
    logic [15:0] divisor_i;
    logic [31:0] result_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
    logic        div_zero_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    logic m_n = 1'b0;
    logic m_z = 1'b0;
    logic m_v = 1'b0;

    qrdiv_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .result_o(result_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o),
        .div_zero_o(div_zero_o), .busy_o(busy_o), .done_o(done_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Vector fields: {kind[1:0], signed, dividend[31:0], divisor[15:0]}; kind 0 ok, 1 overflow, 2 zero divisor.
    localparam int NVEC = 18;
    localparam logic [50:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 32'd100,        16'd7},
        {2'd0, 1'b0, 32'h0000FFFF,   16'd1},
        {2'd1, 1'b0, 32'h00010000,   16'd1},
        {2'd2, 1'b0, 32'd5,          16'd0},
        {2'd0, 1'b1, 32'hFFFFFF9C,   16'd7},
        {2'd0, 1'b1, 32'd100,        16'hFFF9},
        {2'd0, 1'b0, 32'd3,          16'd7},
        {2'd1, 1'b1, 32'h80000000,   16'hFFFF},
        {2'd0, 1'b1, 32'h00007FFF,   16'd1},
        {2'd0, 1'b1, 32'hFFFF8000,   16'd1},
        {2'd1, 1'b1, 32'h00008000,   16'd1},
        {2'd0, 1'b1, 32'hFFFFFFF9,   16'd7},
        {2'd1, 1'b0, 32'hFFFFFFFF,   16'hFFFF},
        {2'd0, 1'b1, 32'h000F4240,   16'h8000},
        {2'd0, 1'b0, 32'h000F4240,   16'h8000},
        {2'd1, 1'b1, 32'hFFFF8000,   16'hFFFF},
        {2'd2, 1'b1, 32'h7FFFFFFF,   16'd0},
        {2'd0, 1'b1, 32'd0,          16'hFFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference; updates the model flags m_n, m_z, m_v.
    task automatic model(input bit s, input logic [31:0] a, input logic [15:0] b,
                         output int kind, output logic [31:0] res);
        longint sa, sb, q, r;
        if (b == 16'd0) begin
            kind = 2; res = a; m_n = 1'b0; m_z = 1'b1; m_v = 1'b0;
            return;
        end
        if (s) begin
            sa = longint'(signed'(a));
            sb = longint'(signed'(b));
        end else begin
            sa = longint'(a);
            sb = longint'(b);
        end
        q = sa / sb;
        r = sa % sb;
        if (s ? (q >= -32768 && q <= 32767) : (q <= 65535)) begin
            kind = 0;
            res  = {r[15:0], q[15:0]};
            m_n  = q[15];
            m_z  = (q[15:0] == 16'd0);
            m_v  = 1'b0;
        end else begin
            kind = 1; res = a; m_v = 1'b1;
        end
    endtask

    // One complete operation with cycle-exact checks; inject pulses start mid-run.
    task automatic run_op(input bit s, input logic [31:0] a, input logic [15:0] b,
                          input bit inject, output int kind);
        logic [31:0] exp_res;
        string rtag;
        model(s, a, b, kind, exp_res);
        rtag = (kind == 2) ? "R7" : (kind == 1) ? "R8" : (s ? "R5" : "R4");
        @(negedge clk);
        start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", {63'd0, busy_o}, 64'd1);
        for (int k = 0; k < 32; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (inject && k == 9) begin
                start_i = 1'b1; dividend_i = ~a; divisor_i = b + 16'd3; signed_i = ~s;
            end
            if (inject && k == 11) start_i = 1'b0;
            if (k == 31) chk("R2 busy until end", {62'd0, busy_o, done_o}, 64'd2);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R3 done and busy at edge 33", {62'd0, done_o, busy_o}, 64'd2);
        chk({rtag, " result"}, {32'd0, result_o}, {32'd0, exp_res});
        chk((kind == 0) ? "R6 flags" : {rtag, " flags"},
            {61'd0, flag_n_o, flag_z_o, flag_v_o}, {61'd0, m_n, m_z, m_v});
        chk("R9 carry clear", {63'd0, flag_c_o}, 64'd0);
        chk("R7 div_zero pulse", {63'd0, div_zero_o}, {63'd0, kind == 2});
        @(posedge clk);
        @(negedge clk);
        chk("R3 done single cycle", {62'd0, done_o, div_zero_o}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int kind;
        logic [31:0] ra;
        logic [15:0] rb;
        rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; dividend_i = '0; divisor_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 result", {32'd0, result_o}, 64'd0);
        chk("R1 flags and status",
            {57'd0, flag_n_o, flag_z_o, flag_v_o, flag_c_o, div_zero_o, busy_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [50:0] v;
            v = VEC[i];
            run_op(v[48], v[47:16], v[15:0], 1'b0, kind);
            chk("table outcome class", 64'(kind), {62'd0, v[50:49]});
            if (i == 8 || i == 9 || i == 10 || i == 15)
                chk("R10 range boundary", {63'd0, flag_v_o}, {63'd0, v[50:49] == 2'd1});
        end

        // R2: start while busy is ignored
        run_op(1'b1, 32'hFFFFFC18, 16'd10, 1'b1, kind);
        chk("R2 ignored start kept result", {32'd0, result_o}, {32'd0, 32'h0000FF9C});
        @(negedge clk);
        chk("R2 idle after ignored start", {63'd0, busy_o}, 64'd0);

        // R10: 0x80000000 / -1 overflow after a zero quotient
        run_op(1'b0, 32'd1, 16'd2, 1'b0, kind);
        run_op(1'b1, 32'h80000000, 16'hFFFF, 1'b0, kind);
        chk("R10 min by minus one overflows", {63'd0, flag_v_o}, 64'd1);

        // Random operands, signed and unsigned
        for (int j = 0; j < 48; j++) begin
            ra = $urandom() >> ($urandom() % 32);
            rb = 16'($urandom() >> ($urandom() % 16));
            run_op(j[0], ra, rb, 1'b0, kind);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule